// File: doc/BRIEF.md
# Center-Aligned Multiphase Envelope PWM

This block turns a 6-bit envelope amplitude code into one pulse per reference period. The pulse is centered on the middle of that period. Each period is split into 128 equal phase slots, one per tick of a fine clock. The slot index is built from two counters: a 3-bit tap index that steps through eight positions of a cyclic delay line, and a 4-bit lap counter that records how many times that line has been traversed.

A period-start strobe marks slot 0. On that same edge the block latches the amplitude code. A selector then splits the slots into two halves. The rising edge is placed in the first half and the falling edge in the mirrored position of the second half, so the pulse widens outward from the center as the code grows. The pulse is produced by a register, so it carries no decode glitches.

In the intended system the strobe arrives once every 128 fine-clock ticks, in step with the reference clock. If the strobe is missing, the counter keeps running and repeats the last period. If the strobe comes early, the period restarts.

Top module: `ppwm_envelope`

## Requirements
- R1: While `rst` is high, and after reset until the first edge at which `period_start` is high, `pwm_out` is 0.
- R2: The edge at which `period_start` is high is slot 0. Each following edge advances the slot by one. The slot number is lap×8+tap: the tap index steps every edge, and the lap counter steps when the tap index wraps from 7 to 0.
- R3: `env_code` is read as an unsigned binary value N, and only on the edge where `period_start` is high. Changes to `env_code` at any other edge have no effect on the pulse.
- R4: For code N, the output is high for exactly 2N+2 consecutive cycles per period.
- R5: The output is high in the cycles that follow the edges of slots 63−N through 64+N inclusive. The rising edge therefore always falls in the first half (slots 0–63), the falling edge in the second half (slots 64–127), and the first and last high slots always add up to 127.
- R6: The extreme codes behave as follows. N=0 gives a 2-cycle pulse around slots 63 and 64. N=63 keeps the output high for all 128 slots. No code ever leaves the output fully off.
- R7: If no strobe arrives, the slot wraps from 127 to 0 and the period repeats with the code held from the last strobe.
- R8: A strobe that arrives while a period is in progress restarts counting at slot 0 with the newly sampled code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fine clock, one tick per phase slot |
| rst | input | 1 | Synchronous reset, active high |
| period_start | input | 1 | Strobe marking slot 0 of a reference period |
| env_code | input | 6 | Envelope amplitude code N, sampled at the strobe |
| pwm_out | output | 1 | Registered center-aligned pulse |

## Verification
The bench builds the block with its default 8 taps and 16 laps, which gives 128 slots and 6-bit codes. With these values the bench can sweep every code from 0 to 63 in back-to-back periods. The full sweep covers every lap-carry position and both width extremes, including the full-period pulse that spans into the next period. Further sequences check that code changes in mid-period are ignored, that a period repeats when the strobe is withheld, that an early strobe cuts a wide pulse short, and that a reset in mid-period forces the output low.

// File: rtl/ppwm_pkg.sv
package ppwm_pkg;

    // Which half of the period a slot belongs to.
    typedef enum logic {
        HALF_RISE = 1'b0,
        HALF_FALL = 1'b1
    } half_e;

    function automatic int unsigned width_of(input int unsigned n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/ppwm_slot_counter.sv
module ppwm_slot_counter #(
    parameter int unsigned TAPS = 8,
    parameter int unsigned LAPS = 16,
    localparam int unsigned TAP_W = ppwm_pkg::width_of(TAPS),
    localparam int unsigned LAP_W = ppwm_pkg::width_of(LAPS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    output logic             active,
    output logic [TAP_W-1:0] tap_now,
    output logic [LAP_W-1:0] lap_now
);

    typedef struct packed {
        logic             run;
        logic [TAP_W-1:0] tap;
        logic [LAP_W-1:0] lap;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        tap_now = start ? '0 : cnt_q.tap;
        lap_now = start ? '0 : cnt_q.lap;
        cnt_d   = cnt_q;
        if (rst) begin
            cnt_d = '0;
        end else if (start || cnt_q.run) begin
            cnt_d.run = 1'b1;
            if (tap_now == TAP_W'(TAPS - 1)) begin
                cnt_d.tap = '0;
                cnt_d.lap = (lap_now == LAP_W'(LAPS - 1)) ? '0 : lap_now + LAP_W'(1);
            end else begin
                cnt_d.tap = tap_now + TAP_W'(1);
                cnt_d.lap = lap_now;
            end
        end
    end

    always_ff @(posedge clk) begin
        cnt_q <= cnt_d;
    end

    assign active = start | cnt_q.run;

    // R2: tap index steps by one per edge
    p_tap_step_r2: assert property (@(posedge clk) disable iff (rst)
        (active && tap_now != TAP_W'(TAPS - 1)) |=>
        (start || tap_now == $past(tap_now) + TAP_W'(1)));

    // R2: lap counter steps when the tap index wraps
    p_lap_carry_r2: assert property (@(posedge clk) disable iff (rst)
        (active && tap_now == TAP_W'(TAPS - 1) && lap_now != LAP_W'(LAPS - 1)) |=>
        (start || (tap_now == '0 && lap_now == $past(lap_now) + LAP_W'(1))));

    // R7: last slot wraps to slot 0 and counting goes on
    p_wrap_r7: assert property (@(posedge clk) disable iff (rst)
        (active && tap_now == TAP_W'(TAPS - 1) && lap_now == LAP_W'(LAPS - 1)) |=>
        (start || (active && tap_now == '0 && lap_now == '0)));

    // R8: a strobe restarts the count, so slot 1 follows it
    p_restart_r8: assert property (@(posedge clk) disable iff (rst)
        start |=> (start || (tap_now == TAP_W'(1) && lap_now == '0)));

endmodule

// File: rtl/ppwm_edge_select.sv
module ppwm_edge_select #(
    parameter int unsigned SLOTS = 128,
    localparam int unsigned SLOT_W = $clog2(SLOTS),
    localparam int unsigned HALF   = SLOTS / 2,
    localparam int unsigned CODE_W = $clog2(HALF)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              active,
    input  logic [CODE_W-1:0] code,
    input  logic [SLOT_W-1:0] slot,
    output logic              in_window,
    output logic              first_half
);
    import ppwm_pkg::*;

    typedef struct packed {
        logic [CODE_W-1:0] code;
    } sel_t;

    sel_t              sel_d, sel_q;
    logic [CODE_W-1:0] eff_code;
    logic [CODE_W-1:0] pos;
    half_e             half;

    always_comb begin
        eff_code = start ? code : sel_q.code;
        half     = slot[SLOT_W-1] ? HALF_FALL : HALF_RISE;
        pos      = slot[CODE_W-1:0];
        // The rise slot is HALF-1-N, the mirror of N inside the first half.
        if (half == HALF_RISE) begin
            in_window = active && (pos >= ~eff_code);
        end else begin
            in_window = active && (pos <= eff_code);
        end
        first_half = (half == HALF_RISE);

        sel_d = sel_q;
        if (rst) begin
            sel_d = '0;
        end else if (start) begin
            sel_d.code = code;
        end
    end

    always_ff @(posedge clk) begin
        sel_q <= sel_d;
    end

    // R3: the held code moves only on a strobe edge
    p_code_frozen_r3: assert property (@(posedge clk) disable iff (rst)
        !start |=> $stable(sel_q.code));

    // R6: the two center slots are inside every window
    p_center_covered_r6: assert property (@(posedge clk) disable iff (rst)
        (active && (slot == SLOT_W'(HALF - 1) || slot == SLOT_W'(HALF))) |-> in_window);

endmodule

// File: rtl/ppwm_pulse_shaper.sv
module ppwm_pulse_shaper (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic active,
    input  logic in_window,
    input  logic first_half,
    output logic pwm
);

    typedef struct packed {
        logic pwm;
    } out_t;

    out_t out_d, out_q;

    always_comb begin
        out_d     = out_q;
        out_d.pwm = rst ? 1'b0 : (active & in_window);
    end

    always_ff @(posedge clk) begin
        out_q <= out_d;
    end

    assign pwm = out_q.pwm;

    // R1: no pulse before counting has begun
    p_idle_low_r1: assert property (@(posedge clk) disable iff (rst)
        !$past(active) |-> !pwm);

    // R5: the rising edge is taken in the first half
    p_rise_first_half_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(pwm) |-> $past(first_half));

    // R5: the falling edge is taken in the second half unless a strobe cut it
    p_fall_second_half_r5: assert property (@(posedge clk) disable iff (rst)
        ($fell(pwm) && !$past(start)) |-> !$past(first_half));

endmodule

// File: rtl/ppwm_envelope.sv
module ppwm_envelope #(
    parameter int unsigned TAPS = 8,
    parameter int unsigned LAPS = 16,
    localparam int unsigned SLOTS  = TAPS * LAPS,
    localparam int unsigned SLOT_W = $clog2(SLOTS),
    localparam int unsigned CODE_W = $clog2(SLOTS / 2),
    localparam int unsigned TAP_W  = ppwm_pkg::width_of(TAPS),
    localparam int unsigned LAP_W  = ppwm_pkg::width_of(LAPS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              period_start,
    input  logic [CODE_W-1:0] env_code,
    output logic              pwm_out
);

    logic              active;
    logic [TAP_W-1:0]  tap_now;
    logic [LAP_W-1:0]  lap_now;
    logic [SLOT_W-1:0] slot;
    logic              in_window;
    logic              first_half;

    ppwm_slot_counter #(.TAPS(TAPS), .LAPS(LAPS)) u_count (
        .clk     (clk),
        .rst     (rst),
        .start   (period_start),
        .active  (active),
        .tap_now (tap_now),
        .lap_now (lap_now)
    );

    // Slot number: laps of the cyclic line above, tap position below.
    assign slot = SLOT_W'(lap_now) * SLOT_W'(TAPS) + SLOT_W'(tap_now);

    ppwm_edge_select #(.SLOTS(SLOTS)) u_sel (
        .clk        (clk),
        .rst        (rst),
        .start      (period_start),
        .active     (active),
        .code       (env_code),
        .slot       (slot),
        .in_window  (in_window),
        .first_half (first_half)
    );

    ppwm_pulse_shaper u_shape (
        .clk        (clk),
        .rst        (rst),
        .start      (period_start),
        .active     (active),
        .in_window  (in_window),
        .first_half (first_half),
        .pwm        (pwm_out)
    );

endmodule

// File: tb/ppwm_envelope_test.sv
`timescale 1ns/1ps
module ppwm_envelope_test;

    localparam int SLOTS = 128;
    localparam int HALF  = 64;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       period_start = 1'b0;
    logic [5:0] env_code = '0;
    logic       pwm_out;

    always #2.5 clk = ~clk;

    ppwm_envelope uut (
        .clk          (clk),
        .rst          (rst),
        .period_start (period_start),
        .env_code     (env_code),
        .pwm_out      (pwm_out)
    );

    typedef struct {
        logic  exp;
        string tag;
    } item_t;

    item_t sb[$];
    int    checks = 0;
    int    fails  = 0;
    bit    done   = 0;

    // Reference model state, built from the requirements.
    bit m_run  = 0;
    int m_slot = 0;
    int m_code = 0;

    // Monitor measurements.
    int   off = 0, rise_off = 0, run = 0, last_run = -1, last_rise = -1;
    logic prev = 1'b0;

    task automatic chk(input bit ok, input string tag, input int got, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s got=%0d expected=%0d", tag, got, exp);
        end
    endtask

    // Drives one edge's inputs and pushes the output expected after it.
    task automatic step(input logic rs, input logic s, input int c, input string tag);
        int cur;
        bit win;
        @(negedge clk);
        rst          = rs;
        period_start = s;
        env_code     = 6'(c);
        if (rs) begin
            m_run = 0;
            m_slot = 0;
            m_code = 0;
            win = 0;
        end else begin
            if (s) begin
                cur = 0;
                m_code = c;
                m_run = 1;
            end else begin
                cur = m_slot;
            end
            win = m_run && (cur >= HALF - 1 - m_code) && (cur <= HALF + m_code);
            if (m_run) m_slot = (cur + 1) % SLOTS;
        end
        sb.push_back('{exp: win, tag: tag});
    endtask

    // Monitor: pops the scoreboard and measures pulse runs.
    always begin
        @(posedge clk);
        #1;
        if (period_start) off = 0;
        else off++;
        if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            checks++;
            if (pwm_out !== it.exp) begin
                fails++;
                $display("FAIL %s pwm_out got=%b expected=%b at t=%0t", it.tag, pwm_out, it.exp, $time);
            end
        end
        if (pwm_out === 1'b1 && prev !== 1'b1) begin
            rise_off = off;
            run = 1;
        end else if (pwm_out === 1'b1) begin
            run++;
        end else if (prev === 1'b1) begin
            last_run  = run;
            last_rise = rise_off;
        end
        prev = pwm_out;
    end

    task automatic check_run(input int n, input int exp_rise, input string tag);
        chk(last_run == 2 * n + 2, {tag, " R4 width"}, last_run, 2 * n + 2);
        chk(last_rise == exp_rise, {tag, " R5 rise slot"}, last_rise, exp_rise);
    endtask

    initial begin
        // R1: reset holds the output low
        for (int i = 0; i < 4; i++) step(1, 0, 0, "R1 reset");
        chk(pwm_out === 1'b0, "R1 reset output", int'(pwm_out), 0);
        for (int i = 0; i < 12; i++) step(0, 0, 33, "R1 idle");
        chk(pwm_out === 1'b0, "R1 idle output", int'(pwm_out), 0);

        // R2/R4/R5: sweep of all codes in back-to-back periods
        for (int n = 0; n < 64; n++) begin
            step(0, 1, n, "R2 sweep");
            if (n > 0) begin
                check_run(n - 1, HALF - 1 - (n - 1), (n == 1) ? "R6 code0" : "sweep");
                chk(2 * last_rise + last_run - 1 == SLOTS - 1, "R5 midpoint",
                    2 * last_rise + last_run - 1, SLOTS - 1);
            end
            for (int k = 1; k < SLOTS; k++) step(0, 0, n, "R2 sweep");
        end

        // R6: code 63 covers the whole period
        step(0, 1, 0, "R6 full");
        step(0, 0, 0, "R6 full");
        chk(last_run == SLOTS, "R6 full width", last_run, SLOTS);
        chk(last_rise == 0, "R6 full rise", last_rise, 0);
        for (int k = 2; k < SLOTS; k++) step(0, 0, 0, "R6 code0");

        // R3: code changes inside the period are ignored
        step(0, 1, 10, "R3 hold");
        for (int k = 1; k < SLOTS; k++) step(0, 0, (k < 30) ? 10 : ((k < 60) ? 50 : 1), "R3 hold");
        step(0, 1, 0, "R3 hold");
        check_run(10, 53, "R3");
        for (int k = 1; k < SLOTS; k++) step(0, 0, 0, "R3 tail");

        // R7: no strobe, so the period repeats with the held code
        step(0, 1, 5, "R7 repeat");
        for (int k = 1; k < 2 * SLOTS; k++) step(0, 0, 20, "R7 repeat");
        check_run(5, SLOTS + 58, "R7");

        // R8: an early strobe restarts the period
        step(0, 1, 40, "R8 restart");
        for (int k = 1; k < 70; k++) step(0, 0, 40, "R8 restart");
        step(0, 1, 2, "R8 restart");
        step(0, 0, 2, "R8 restart");
        chk(last_run == 47, "R8 cut width", last_run, 47);
        for (int k = 2; k < SLOTS; k++) step(0, 0, 2, "R8 restart");
        step(0, 1, 2, "R8 restart");
        check_run(2, 61, "R8");

        // R1: reset in mid-period, then no strobe, keeps the output low
        for (int k = 1; k < 70; k++) step(0, 0, 2, "R1 mid");
        step(1, 0, 0, "R1 mid reset");
        for (int k = 0; k < 200; k++) step(0, 0, 63, "R1 after reset");
        chk(pwm_out === 1'b0, "R1 after reset output", int'(pwm_out), 0);

        step(0, 0, 0, "R1 drain");
        step(0, 0, 0, "R1 drain");
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog got=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule